// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a free-running pixel clock into the timing skeleton of a raster display: a horizontal sync, a vertical sync, a display-enable that is high only over the visible picture, and the current pixel column and line as counters. Each line is walked as four segments in a fixed order: visible pixels, front porch, sync pulse, back porch. Each frame is walked in the same order, counted in lines. The line advances once per line, in the cycle after the last back-porch pixel of the horizontal sweep.

All eight segment lengths, four per axis, sit in registers that a controller writes over a plain write strobe, address and data. Writes land in a shadow set at any time. The working set that drives the counters is reloaded from the shadow only as the counters wrap to the first pixel of a new frame, so a frame is never built from two configurations. The sync levels are also given as a two-bit flag word that a processor can poll, so it can place its own accesses inside blanking. The reset values of the registers are parameters; their defaults give a 1920x1080 picture with 2430 clocks per line and 1139 lines per frame.

Top module: `vtg_top`

## Requirements
- R1: While reset is asserted, pix_x and pix_y are 0 and hsync and vsync are low.
- R2: hsync is high, active high, exactly for pix_x from (h_act+h_fp) up to but not including (h_act+h_fp+h_sync), and low otherwise.
- R3: pix_x counts up by one every clock from 0 to (h_act+h_fp+h_sync+h_bp-1) and then returns to 0.
- R4: pix_y advances by one in the clock after pix_x reaches its last value; vsync is high, active high, exactly on lines from (v_act+v_fp) up to but not including (v_act+v_fp+v_sync), and changes only when pix_x is 0.
- R5: A frame is (v_act+v_fp+v_sync+v_bp) lines; after the last line pix_y returns to 0 together with pix_x.
- R6: de is high exactly when pix_x < h_act and pix_y < v_act.
- R7: A clock with wr_en high stores wr_data in the register at wr_addr: 0 h_act, 1 h_fp, 2 h_sync, 3 h_bp, 4 v_act, 5 v_fp, 6 v_sync, 7 v_bp.
- R8: Register writes change the outputs only from the next frame start (pix_x = 0 and pix_y = 0) on; the frame in progress keeps its timing to the end.
- R9: A segment length written as 0 behaves as a length of 1.
- R10: sync_flags[0] equals hsync and sync_flags[1] equals vsync in every clock.
- R11: After reset the first frame uses the parameter reset values of all eight lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index, see R7 |
| wr_data | input | CNT_W | Segment length to store |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Visible-picture enable |
| pix_x | output | CNT_W+2 | Clock position within the line |
| pix_y | output | CNT_W+2 | Line position within the frame |
| sync_flags | output | 2 | Pollable sync state {vsync, hsync} |

## Verification
The bench compares every output against a model of the segment arithmetic over whole frames for several timings, including one with zero-length porches, which a design without the length-of-one floor would collapse or stall on, and one with all lengths at one, where an off-by-one in the segment end test shows up as a line of wrong length. A write placed in the first clock of a frame targets the reload boundary: a design that reloaded the working set immediately would shorten the rest of that frame, and one that never reloaded would keep the old line length forever. The reset defaults are checked on the first frame, catching a design that reloads before the first wrap or resets the working set to zero.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // segment order along either axis; the order is the scan behaviour
  typedef enum logic [1:0] {
    SEG_ACT  = 2'd0,
    SEG_FP   = 2'd1,
    SEG_SYNC = 2'd2,
    SEG_BP   = 2'd3
  } seg_e;

  localparam int NUM_SEGS = 4;
  localparam int NUM_REGS = 2 * NUM_SEGS;

  function automatic seg_e seg_after(input seg_e s);
    case (s)
      SEG_ACT:  return SEG_FP;
      SEG_FP:   return SEG_SYNC;
      SEG_SYNC: return SEG_BP;
      default:  return SEG_ACT;
    endcase
  endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter logic [NUM_REGS-1:0][CNT_W-1:0] INIT = '0,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CNT_W-1:0]                  wr_data,
  input  logic                              reload,
  output logic [NUM_REGS-1:0][CNT_W-1:0]    live
);

  logic [NUM_REGS-1:0][CNT_W-1:0] shadow;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i] <= INIT[i];
        live[i]   <= INIT[i];
      end else begin
        if (wr_en && (wr_addr == ADDR_W'(i)))
          shadow[i] <= wr_data;
        if (reload)
          live[i] <= shadow[i];
      end
    end
  end

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12,
  localparam int POS_W = CNT_W + 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  logic [NUM_SEGS-1:0][CNT_W-1:0]    len,
  output seg_e                              seg,
  output logic [POS_W-1:0]                  pos,
  output logic                              last
);

  logic [CNT_W-1:0] seg_cnt;
  logic [CNT_W:0]   cnt_next;
  logic             seg_done;

  assign cnt_next = {1'b0, seg_cnt} + 1'b1;
  // a zero length ends after one step, the same as a length of one
  assign seg_done = cnt_next >= {1'b0, len[seg]};
  assign last     = (seg == SEG_BP) && seg_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg     <= SEG_ACT;
      seg_cnt <= '0;
      pos     <= '0;
    end else if (adv) begin
      if (seg_done) begin
        seg     <= seg_after(seg);
        seg_cnt <= '0;
      end else begin
        seg_cnt <= cnt_next[CNT_W-1:0];
      end
      pos <= last ? '0 : pos + 1'b1;
    end
  end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int RST_H_ACT = 1920,
  parameter int RST_H_FP  = 205,
  parameter int RST_H_SYN = 50,
  parameter int RST_H_BP  = 255,
  parameter int RST_V_ACT = 1080,
  parameter int RST_V_FP  = 2,
  parameter int RST_V_SYN = 55,
  parameter int RST_V_BP  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [CNT_W+1:0]   pix_x,
  output logic [CNT_W+1:0]   pix_y,
  output logic [1:0]         sync_flags
);

  localparam logic [NUM_REGS-1:0][CNT_W-1:0] RST_SET = {
    CNT_W'(RST_V_BP), CNT_W'(RST_V_SYN), CNT_W'(RST_V_FP), CNT_W'(RST_V_ACT),
    CNT_W'(RST_H_BP), CNT_W'(RST_H_SYN), CNT_W'(RST_H_FP), CNT_W'(RST_H_ACT)
  };

  logic [NUM_REGS-1:0][CNT_W-1:0] cur_cfg;
  logic [NUM_SEGS-1:0][CNT_W-1:0] h_len, v_len;
  seg_e h_seg, v_seg;
  logic h_last, v_last, frame_wrap;

  assign h_len      = cur_cfg[NUM_SEGS-1:0];
  assign v_len      = cur_cfg[NUM_REGS-1:NUM_SEGS];
  assign frame_wrap = h_last && v_last;

  vtg_regs #(.CNT_W(CNT_W), .INIT(RST_SET)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .reload  (frame_wrap),
    .live    (cur_cfg)
  );

  vtg_axis #(.CNT_W(CNT_W)) u_h (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (1'b1),
    .len   (h_len),
    .seg   (h_seg),
    .pos   (pix_x),
    .last  (h_last)
  );

  vtg_axis #(.CNT_W(CNT_W)) u_v (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (h_last),
    .len   (v_len),
    .seg   (v_seg),
    .pos   (pix_y),
    .last  (v_last)
  );

  assign hsync      = (h_seg == SEG_SYNC);
  assign vsync      = (v_seg == SEG_SYNC);
  assign de         = (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
  assign sync_flags = {vsync, hsync};

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
  parameter int CNT_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hsync,
  input logic                 vsync,
  input logic                 de,
  input logic [CNT_W+1:0]     pix_x,
  input logic [CNT_W+1:0]     pix_y,
  input logic [7:0][CNT_W-1:0] cur_cfg
);

  // R6
  de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  // R3
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != 0) |-> (pix_x == (CNT_W+2)'($past(pix_x) + 1'b1)));

  // R4
  y_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_y) |-> (pix_x == 0));

  // R4
  vs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> (pix_x == 0));

  // R5
  y_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x == 0 && pix_y != 0) |-> (pix_y == (CNT_W+2)'($past(pix_y) + 1'b1)));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != 0 || pix_y != 0) |-> $stable(cur_cfg));

endmodule

bind vtg_top vtg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hsync   (hsync),
  .vsync   (vsync),
  .de      (de),
  .pix_x   (pix_x),
  .pix_y   (pix_y),
  .cur_cfg (cur_cfg)
);

// File: tb/vtg_top_test.sv
module vtg_top_test;

  localparam int CNT_W = 12;
  localparam int NCFG  = 4;
  // h_act h_fp h_sync h_bp v_act v_fp v_sync v_bp
  localparam int DEF [8] = '{8, 2, 3, 2, 4, 1, 2, 1};
  localparam int CFG [NCFG][8] = '{
    '{5, 1, 1, 3, 3, 2, 1, 2},
    '{6, 0, 2, 1, 2, 0, 1, 0},
    '{1, 1, 1, 1, 1, 1, 1, 1},
    '{8, 2, 3, 2, 4, 1, 2, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic hsync, vsync, de;
  logic [CNT_W+1:0] pix_x, pix_y;
  logic [1:0] sync_flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  vtg_top #(
    .CNT_W(CNT_W),
    .RST_H_ACT(DEF[0]), .RST_H_FP(DEF[1]), .RST_H_SYN(DEF[2]), .RST_H_BP(DEF[3]),
    .RST_V_ACT(DEF[4]), .RST_V_FP(DEF[5]), .RST_V_SYN(DEF[6]), .RST_V_BP(DEF[7])
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .sync_flags(sync_flags)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  // checks outputs from frame clock k0 to the frame end; caller is at a negedge on k0
  task automatic check_span(input int c[8], input int k0, input string ctx);
    int ha = eff(c[0]), hf = eff(c[1]), hs = eff(c[2]), hb = eff(c[3]);
    int va = eff(c[4]), vf = eff(c[5]), vs = eff(c[6]), vb = eff(c[7]);
    int htot = ha + hf + hs + hb;
    int ftot = htot * (va + vf + vs + vb);
    for (int k = k0; k < ftot; k++) begin
      int x = k % htot;
      int y = k / htot;
      bit e_hs = (x >= ha + hf) && (x < ha + hf + hs);
      bit e_vs = (y >= va + vf) && (y < va + vf + vs);
      bit e_de = (x < ha) && (y < va);
      chk(int'(pix_x) == x, {"R3 pix_x ", ctx}, int'(pix_x), x);
      chk(int'(pix_y) == y, {"R4/R5 pix_y ", ctx}, int'(pix_y), y);
      chk(hsync == e_hs, {"R2 hsync ", ctx}, int'(hsync), int'(e_hs));
      chk(vsync == e_vs, {"R4 vsync ", ctx}, int'(vsync), int'(e_vs));
      chk(de == e_de, {"R6 de ", ctx}, int'(de), int'(e_de));
      chk(sync_flags == {vsync, hsync}, {"R10 flags ", ctx},
          int'(sync_flags), int'({vsync, hsync}));
      @(negedge clk);
    end
  endtask

  // R7: one register write, driven at a negedge, returns at the next negedge
  task automatic write_reg(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_frame_start();
    @(negedge clk);
    while (!(pix_x == 0 && pix_y == 0)) @(negedge clk);
  endtask

  initial begin
    int mod_cfg[8];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pix_x == 0, "R1 pix_x in reset", int'(pix_x), 0);
    chk(pix_y == 0, "R1 pix_y in reset", int'(pix_y), 0);
    chk(hsync == 1'b0, "R1 hsync in reset", int'(hsync), 0);
    chk(vsync == 1'b0, "R1 vsync in reset", int'(vsync), 0);
    rst_n = 1'b1;
    // R11: first frame runs the reset values
    check_span(DEF, 0, "R11 reset timing");

    // table of timings, each programmed through R7 and checked over a whole frame
    for (int t = 0; t < NCFG; t++) begin
      for (int a = 0; a < 8; a++) write_reg(a, CFG[t][a]);
      wait_frame_start();
      check_span(CFG[t], 0, $sformatf("R7/R9 table %0d", t));
    end

    // R8: write in the first clock of a frame; old timing holds to the frame end
    for (int a = 0; a < 8; a++) write_reg(a, CFG[0][a]);
    wait_frame_start();
    write_reg(0, 2);
    check_span(CFG[0], 1, "R8 old frame kept");
    mod_cfg = CFG[0];
    mod_cfg[0] = 2;
    check_span(mod_cfg, 0, "R8 new frame");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule